// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 512K bytes. The request side uses a valid/ready handshake, and each request carries a 19-bit word address, a write flag and a write byte. The block turns each single-beat request into a timed sequence on the memory pins: a chip select, an output enable, and a read/write line that is high for read and low for write. The byte bus is tristate and is split into an outgoing value, an incoming value and a drive enable.

Every timing window is a nanosecond parameter. Examples are the access time from address or select, the access time from output enable, the write pulse width, select-to-write-end, data setup before the write ends, cycle time, and the time the memory needs to release the bus. The block turns each window into a cycle count by ceiling division with the clock period. This lets the slower low-voltage timing set be chosen by parameter alone.

Each transaction passes through the states IDLE, SETUP, STROBE, HOLD and, after a read, TURNAROUND. A read returns its byte with a one-cycle response pulse. When nothing is in flight, the chip select stays high so that the memory drops into standby.

Top module: `async_sram_ctl`

## Requirements
- R1: While idle (ready high), chip select, output enable and read/write are all held high and the bus is not driven; the block stays like this for as long as no request arrives.
- R2: During a read, chip select stays low and read/write stays high from SETUP to HOLD, and the controller never drives the bus.
- R3: A read has one SETUP cycle with output enable high, then a STROBE of max(ceil(ACCESS_NS/CLK_NS)-1, ceil(OE_ACCESS_NS/CLK_NS)) cycles with output enable low (6 with defaults). The byte is sampled on the last STROBE edge, so it is at least the address or select access time after select and address, and at least the output-enable access time after output enable.
- R4: The read byte appears on the response data together with a response-valid pulse of exactly one cycle. The pulse is high in the cycle that starts 1+RD_STROBE edges after the accepting edge (7 edges with defaults). Writes produce no pulse.
- R5: During a write, output enable stays high from SETUP to HOLD. Read/write is low for max(ceil(WR_PULSE_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS), ceil(CE_TO_WEND_NS/CLK_NS)-1) cycles (5 with defaults), which meets the pulse width and also the select-low time before the write ends.
- R6: The write byte is driven from SETUP through one HOLD cycle after read/write rises, and it stays unchanged the whole time, so it meets data setup and the memory stores it.
- R7: Chip select stays low at least the read or write cycle time. Ready returns 1+RD_STROBE+RD_HOLD+TA edges after a read is accepted (11 with defaults) and 1+WR_STROBE+WR_HOLD edges after a write is accepted (7 with defaults).
- R8: After a read, the TURNAROUND lasts ceil(RELEASE_NS/CLK_NS) cycles (3 with defaults). The bus is not driven while the memory may still be releasing it, even for a write that follows at once.
- R9: The address pins stay stable for as long as chip select is low.
- R10: A request is taken only on an edge where ready is high, and ready drops on the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqAddr | input | ADDR_W | Word address of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Byte to write |
| rspValid | output | 1 | One-cycle pulse: read byte valid |
| rspRdata | output | DATA_W | Read byte |
| sramAddr | output | ADDR_W | Memory address pins |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramRw | output | 1 | High = read, low = write |
| sramDqOut | output | DATA_W | Byte driven onto the bus |
| sramDqIn | input | DATA_W | Byte sampled from the bus |
| sramDqOe | output | 1 | Drive enable for the bus |

## Verification
The bench builds the block with its default parameters: a 10 ns clock and the fast timing set. These give a read STROBE of 6 cycles, a HOLD of 1 and a TURNAROUND of 3, and a write STROBE of 5 and a HOLD of 1. With a clock that short, every window rounds to several cycles, so an off-by-one in any count shows up in the memory model's width, setup and contention checks, and in the latency and busy lengths seen at the ports. A read followed at once by a write makes the turnaround gap decide whether the bus clashes. Writes at the lowest and highest addresses, with bytes such as all-zeros, all-ones and alternating patterns, exercise the whole width of the address and data paths.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } ctlState_t;

  // Strobes the sequencer hands to the pin datapath each cycle
  typedef struct packed {
    logic chipSelN;
    logic outEnN;
    logic readNotWrite;
    logic busDrive;
    logic loadReq;
    logic capture;
  } sramStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS         = 10,
  parameter int READ_CYCLE_NS  = 70,
  parameter int ACCESS_NS      = 70,
  parameter int OE_ACCESS_NS   = 35,
  parameter int WRITE_CYCLE_NS = 70,
  parameter int WR_PULSE_NS    = 50,
  parameter int CE_TO_WEND_NS  = 60,
  parameter int DATA_SETUP_NS  = 30,
  parameter int RELEASE_NS     = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output sramStrobes_t strb
);

  // Cycle counts derived by ceiling division
  localparam int RD_STB = maxOf(1, maxOf(ceilDiv(ACCESS_NS, CLK_NS) - 1,
                                         ceilDiv(OE_ACCESS_NS, CLK_NS)));
  localparam int RD_HLD = maxOf(1, ceilDiv(READ_CYCLE_NS, CLK_NS) - 1 - RD_STB);
  localparam int WR_STB = maxOf(1, maxOf(maxOf(ceilDiv(WR_PULSE_NS, CLK_NS),
                                               ceilDiv(DATA_SETUP_NS, CLK_NS)),
                                         ceilDiv(CE_TO_WEND_NS, CLK_NS) - 1));
  localparam int WR_HLD = maxOf(1, ceilDiv(WRITE_CYCLE_NS, CLK_NS) - 1 - WR_STB);
  localparam int TA_CYC = maxOf(1, ceilDiv(RELEASE_NS, CLK_NS));
  localparam int MAX_CNT = maxOf(maxOf(RD_STB, RD_HLD),
                                 maxOf(maxOf(WR_STB, WR_HLD), TA_CYC));
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] RD_STB_M1 = CNT_W'(RD_STB - 1);
  localparam logic [CNT_W-1:0] RD_HLD_M1 = CNT_W'(RD_HLD - 1);
  localparam logic [CNT_W-1:0] WR_STB_M1 = CNT_W'(WR_STB - 1);
  localparam logic [CNT_W-1:0] WR_HLD_M1 = CNT_W'(WR_HLD - 1);
  localparam logic [CNT_W-1:0] TA_M1     = CNT_W'(TA_CYC - 1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_SETUP;
            isWr  <= reqWrite;
            cnt   <= '0;
          end
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt   <= isWr ? WR_STB_M1 : RD_STB_M1;
        end
        ST_STROBE: begin
          if (cntDone) begin
            state <= ST_HOLD;
            cnt   <= isWr ? WR_HLD_M1 : RD_HLD_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cntDone) begin
            if (isWr) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_TURN;
              cnt   <= TA_M1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '{chipSelN: 1'b1, outEnN: 1'b1, readNotWrite: 1'b1,
             busDrive: 1'b0, loadReq: 1'b0, capture: 1'b0};
    unique case (state)
      ST_IDLE:  strb.loadReq = reqValid;
      ST_SETUP: begin
        strb.chipSelN = 1'b0;
        strb.busDrive = isWr;
      end
      ST_STROBE: begin
        strb.chipSelN = 1'b0;
        if (isWr) begin
          strb.readNotWrite = 1'b0;
          strb.busDrive     = 1'b1;
        end else begin
          strb.outEnN  = 1'b0;
          strb.capture = cntDone;
        end
      end
      ST_HOLD: begin
        strb.chipSelN = 1'b0;
        strb.busDrive = isWr;
      end
      ST_TURN: ;
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramRw,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  // Address and write byte are held for the whole transaction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  // Sample point at the end of the access window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      rspQ <= strb.capture;
      if (strb.capture) rdataQ <= sramDqIn;
    end
  end

  assign sramAddr  = addrQ;
  assign sramCeN   = strb.chipSelN;
  assign sramOeN   = strb.outEnN;
  assign sramRw    = strb.readNotWrite;
  assign sramDqOe  = strb.busDrive;
  assign sramDqOut = wdataQ;
  assign rspValid  = rspQ;
  assign rspRdata  = rdataQ;

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS         = 10,
  parameter int READ_CYCLE_NS  = 70,
  parameter int ACCESS_NS      = 70,
  parameter int OE_ACCESS_NS   = 35,
  parameter int WRITE_CYCLE_NS = 70,
  parameter int WR_PULSE_NS    = 50,
  parameter int CE_TO_WEND_NS  = 60,
  parameter int DATA_SETUP_NS  = 30,
  parameter int RELEASE_NS     = 25,
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramRw,
  output logic [DATA_W-1:0] sramDqOut,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              sramDqOe
);

  sramStrobes_t strb;

  sram_ctl_fsm #(
    .CLK_NS        (CLK_NS),
    .READ_CYCLE_NS (READ_CYCLE_NS),
    .ACCESS_NS     (ACCESS_NS),
    .OE_ACCESS_NS  (OE_ACCESS_NS),
    .WRITE_CYCLE_NS(WRITE_CYCLE_NS),
    .WR_PULSE_NS   (WR_PULSE_NS),
    .CE_TO_WEND_NS (CE_TO_WEND_NS),
    .DATA_SETUP_NS (DATA_SETUP_NS),
    .RELEASE_NS    (RELEASE_NS)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sram_ctl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sramDqIn (sramDqIn),
    .sramAddr (sramAddr),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramRw   (sramRw),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int WR_PULSE_NS = 50,
  parameter int RELEASE_NS  = 25,
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramRw,
  input logic [DATA_W-1:0] sramDqOut,
  input logic              sramDqOe
);

  localparam int WP_CYC  = ceilDiv(WR_PULSE_NS, CLK_NS);
  localparam int REL_CYC = ceilDiv(RELEASE_NS, CLK_NS);
  localparam int WP_W    = $clog2(WP_CYC + 1) + 1;
  localparam int REL_W   = $clog2(REL_CYC + 1) + 1;
  localparam logic [WP_W-1:0]  WP_L  = WP_W'(WP_CYC);
  localparam logic [REL_W-1:0] REL_L = REL_W'(REL_CYC);

  logic [WP_W-1:0]  wrLowCnt;
  logic [REL_W-1:0] oeHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrLowCnt  <= '0;
      oeHighCnt <= REL_L;
    end else begin
      if (sramRw)               wrLowCnt <= '0;
      else if (wrLowCnt < WP_L) wrLowCnt <= wrLowCnt + 1'b1;
      if (!sramOeN)              oeHighCnt <= '0;
      else if (oeHighCnt < REL_L) oeHighCnt <= oeHighCnt + 1'b1;
    end
  end

  assert_standby_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (sramCeN && sramOeN && sramRw && !sramDqOe));

  assert_read_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> (sramRw && !sramCeN && !sramDqOe));

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_oe_high_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sramRw |-> (sramOeN && !sramCeN && sramDqOe));

  assert_wp_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramRw) |-> (wrLowCnt >= WP_L));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramRw) |-> (sramDqOe && $stable(sramDqOut)));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (oeHighCnt >= REL_L));

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind async_sram_ctl sram_ctl_chk #(
  .CLK_NS     (CLK_NS),
  .WR_PULSE_NS(WR_PULSE_NS),
  .RELEASE_NS (RELEASE_NS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .sramAddr (sramAddr),
  .sramCeN  (sramCeN),
  .sramOeN  (sramOeN),
  .sramRw   (sramRw),
  .sramDqOut(sramDqOut),
  .sramDqOe (sramDqOe)
);

// File: tb/async_sram_ctl_bench.sv
module async_sram_ctl_bench;

  localparam int CLK = 10;
  localparam int TRC = 70, TACC = 70, TOE = 35, TWC = 70;
  localparam int TWP = 50, TCW = 60, TDS = 30, TREL = 25;
  localparam int AW = 19, DW = 8;

  function automatic int cdiv(input int n);
    return (n + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_STB  = mx(cdiv(TACC) - 1, cdiv(TOE));
  localparam int RD_HLD  = mx(1, cdiv(TRC) - 1 - RD_STB);
  localparam int WR_STB  = mx(mx(cdiv(TWP), cdiv(TDS)), cdiv(TCW) - 1);
  localparam int WR_HLD  = mx(1, cdiv(TWC) - 1 - WR_STB);
  localparam int TA      = cdiv(TREL);
  localparam int RSP_AT  = 1 + RD_STB + 1;
  localparam int RD_BUSY = 1 + RD_STB + RD_HLD + TA + 1;
  localparam int WR_BUSY = 1 + WR_STB + WR_HLD + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic          reqWrite = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] sramAddr;
  logic          sramCeN, sramOeN, sramRw, sramDqOe;
  logic [DW-1:0] sramDqOut;
  logic [DW-1:0] sramDqIn = '0;

  int checkCount = 0;
  int failCount  = 0;
  int modelErr   = 0;

  always #5 clk = ~clk;

  async_sram_ctl u_async_sram_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramRw(sramRw),
    .sramDqOut(sramDqOut), .sramDqIn(sramDqIn), .sramDqOe(sramDqOe)
  );

  // Behavioural memory: counts cycles per pin at each falling edge
  logic [DW-1:0] mem [logic [AW-1:0]];
  int ceLow = 0, rwLow = 0, oeLow = 0, addrCnt = 0, dataCnt = 0, relLeft = 0;
  logic prevCe = 1'b1, prevRw = 1'b1, prevDqOe = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevDq = '0;

  task automatic modelViolation(input string what);
    modelErr++;
    $display("memory model violation: %s at %0t", what, $time);
  endtask

  always @(negedge clk) begin
    logic memActive;
    if (!rstN) begin
      ceLow = 0; rwLow = 0; oeLow = 0; addrCnt = 0; dataCnt = 0; relLeft = 0;
      prevCe = 1'b1; prevRw = 1'b1; prevDqOe = 1'b0;
    end else begin
      if (!prevRw && sramRw) begin
        if (rwLow * CLK < TWP)   modelViolation("write pulse width");
        if (ceLow * CLK < TCW)   modelViolation("select to write end");
        if (dataCnt * CLK < TDS) modelViolation("data setup");
        mem[prevAddr] = prevDq;
      end
      if (!prevCe && sramCeN && ceLow * CLK < mx(TRC, TWC))
        modelViolation("cycle time");
      memActive = !sramCeN && !sramOeN && sramRw;
      if (sramDqOe && (memActive || relLeft > 0)) modelViolation("bus contention");
      ceLow   = sramCeN ? 0 : ceLow + 1;
      rwLow   = sramRw  ? 0 : rwLow + 1;
      oeLow   = sramOeN ? 0 : oeLow + 1;
      addrCnt = (sramAddr == prevAddr) ? addrCnt + 1 : 1;
      dataCnt = !sramDqOe ? 0 :
                ((prevDqOe && sramDqOut == prevDq) ? dataCnt + 1 : 1);
      relLeft = memActive ? TA : ((relLeft > 0) ? relLeft - 1 : 0);
      prevCe = sramCeN; prevRw = sramRw; prevDqOe = sramDqOe;
      prevAddr = sramAddr; prevDq = sramDqOut;
      if (memActive && ceLow * CLK >= TACC && oeLow * CLK >= TOE &&
          addrCnt * CLK >= TACC)
        sramDqIn = mem.exists(sramAddr) ? mem[sramAddr] : 8'h00;
      else
        sramDqIn = 8'hEE;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  // Called at a falling edge; issues immediately once ready is seen
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 1, lowCyc = 0, busyAt = 0, errBefore = modelErr;
    bit oeAllHigh = 1'b1, rspSeen = 1'b0;
    issue(1'b1, a, d);
    while (busyAt == 0 && n < 100) begin
      if (reqReady) busyAt = n;
      else begin
        if (!sramOeN) oeAllHigh = 1'b0;
        if (!sramRw) lowCyc++;
        if (rspValid) rspSeen = 1'b1;
        n++;
        @(negedge clk);
      end
    end
    checkEq("R5 output enable high through write", oeAllHigh, 1);
    checkEq("R5 write strobe cycles", lowCyc, WR_STB);
    checkEq("R4 no response pulse on write", rspSeen, 0);
    checkEq("R7 write busy length", busyAt, WR_BUSY);
    checkEq("R6 write timing model clean", modelErr - errBefore, 0);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] expD);
    int n = 1, rspAt = 0, pulses = 0, oeCyc = 0, busyAt = 0, errBefore = modelErr;
    bit rwAllHigh = 1'b1;
    logic [DW-1:0] got = '0;
    issue(1'b0, a, 8'h00);
    while (busyAt == 0 && n < 100) begin
      if (reqReady) busyAt = n;
      else begin
        if (!sramRw || sramDqOe) rwAllHigh = 1'b0;
        if (!sramOeN) oeCyc++;
        if (rspValid) begin
          pulses++;
          if (rspAt == 0) begin rspAt = n; got = rspRdata; end
        end
        n++;
        @(negedge clk);
      end
    end
    checkEq("R2 read keeps rw high and bus undriven", rwAllHigh, 1);
    checkEq("R3 output enable window", oeCyc, RD_STB);
    checkEq("R4 response cycle", rspAt, RSP_AT);
    checkEq("R4 single pulse", pulses, 1);
    checkEq("R3 read data", got, expD);
    checkEq("R7 read busy length", busyAt, RD_BUSY);
    checkEq("R8 read timing model clean", modelErr - errBefore, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R1 reset select high", sramCeN, 1);
    checkEq("R1 reset oe high", sramOeN, 1);
    checkEq("R1 reset rw high", sramRw, 1);
    checkEq("R1 reset bus released", sramDqOe, 0);
    checkEq("R1 reset ready", reqReady, 1);
    checkEq("R4 reset no response", rspValid, 0);
  endtask

  task automatic testIdle();
    bit allIdle = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!sramCeN || !sramOeN || !sramRw || sramDqOe || !reqReady) allIdle = 1'b0;
    end
    checkEq("R1 standby while no request", allIdle, 1);
  endtask

  task automatic testPatterns();
    doWrite(19'h00000, 8'hA5);
    doWrite(19'h7FFFF, 8'h5A);
    doWrite(19'h12345, 8'hFF);
    doWrite(19'h54321, 8'h00);
    doRead(19'h00000, 8'hA5);
    doRead(19'h7FFFF, 8'h5A);
    doRead(19'h12345, 8'hFF);
    doRead(19'h54321, 8'h00);
  endtask

  task automatic testTurnaround();
    // read directly followed by a write: R8 gap must prevent contention
    doRead(19'h12345, 8'hFF);
    doWrite(19'h12345, 8'h3C);
    doRead(19'h12345, 8'h3C);
    doWrite(19'h00001, 8'hC3);
    doWrite(19'h00002, 8'h81);
    doRead(19'h00001, 8'hC3);
    doRead(19'h00002, 8'h81);
  endtask

  task automatic testHeldValid();
    // R10: valid held high across a transaction gives exactly two accepts
    int accepts = 0;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h00100; reqWdata = 8'h77;
    for (int i = 0; i < WR_BUSY + 2; i++) begin
      @(posedge clk);
      if (reqReady) accepts++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
    checkEq("R10 accepts only when ready", accepts, 2);
    doRead(19'h00100, 8'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdle();
    testPatterns();
    testTurnaround();
    testHeldValid();
    testIdle();
    checkEq("R9 R8 model violations overall", modelErr, 0);
    summary();
    $finish;
  end

endmodule